// File: doc/BRIEF.md
# Pulse-Train Transmit Sequencer

This block plays a list of timed levels out on a single output pin. Each list entry is a 16-bit word held in a local RAM window: bit 15 is the level to drive and bits 14:0 are how long to hold it, counted in ticks of a divided clock. A duration of zero marks the end of the list. Software pulses a start input to play the list from entry 0, and may pulse a stop input to abandon it. When the sequencer is not sending, the pin shows a programmable idle level.

In continuous mode the list is replayed from entry 0 each time the end marker is reached. An optional pass counter counts completed passes, raises a loop event when it reaches a programmed limit and, if enabled, halts the sequencer at that point. A separate count of entries sent raises a threshold event once it goes past a programmed value. When the entries run off the end of the RAM window, the read pointer either wraps to address 0 or the run ends with a sticky memory-empty error.

The controller has four states: IDLE (0), FETCH (1), SEND (2) and DONE (3). It moves IDLE→FETCH on start, FETCH→SEND on an entry with a non-zero duration, and FETCH→FETCH (pointer back to 0) on an end marker in continuous mode. FETCH→DONE happens on an end marker when not in continuous mode, or when the pass limit is reached with auto-stop enabled. SEND→FETCH happens after the entry's last tick, and SEND→DONE after the last tick of a window overrun. FETCH or SEND→IDLE happens when a pending stop is taken, and DONE→IDLE always follows.

Top module: `pulse_train_tx`

## Requirements
- R1: After reset the state output is 0 (IDLE), the read address is 0, all event outputs are low and the error flag is low.
- R2: A start pulse seen in IDLE moves the state to FETCH (1) at the next edge with read address 0. A start pulse seen in any other state has no effect.
- R3: A non-end entry drives its bit 15 on the pin from the first SEND cycle through its next fetch cycle. It spends one FETCH cycle plus duration×div SEND cycles, and a divider value of 0 behaves as 1.
- R4: An end marker (bits 14:0 all zero) fetched outside continuous mode leads to one DONE cycle with the end event high, then IDLE.
- R5: A stop pulse during FETCH or SEND is latched, the state is IDLE two edges later, and no end event fires. The latch is cleared once acted on. A stop pulse in IDLE or DONE has no effect.
- R6: A divider-reset pulse during SEND restarts the current tick count from zero, and no tick is taken in that cycle.
- R7: In continuous mode an end marker sends the FETCH state back to address 0 at the next edge, with no end event.
- R8: With the loop count enabled, each end marker in continuous mode increments a 10-bit pass count, which start and the loop-reset pulse clear. The loop event pulses for one cycle, one cycle after the end-marker fetch whose incremented count equals the limit.
- R9: With auto-stop also enabled, that fetch goes to DONE, and the end event fires.
- R10: The threshold event pulses for one cycle, one cycle after the fetch of the entry that makes the count of entries sent since start exceed the 9-bit threshold. It fires at most once per start.
- R11: After a non-end entry at the last window address is fetched with wraparound on, the read address becomes 0.
- R12: With wraparound off, sending the last window entry ends the run in DONE with the error flag set and no end event. The flag stays set until the next accepted start.
- R13: Outside FETCH and SEND, the output enable equals the idle-enable input and the pin equals idle level AND idle enable. In FETCH and SEND the output enable is high.
- R14: The state output encodes IDLE=0, FETCH=1, SEND=2, DONE=3, and the read address shows the RAM word the sequencer will read next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| stop_i | input | 1 | Stop request pulse |
| div_rst_i | input | 1 | Clears the tick divider count |
| div_i | input | 8 | Clock cycles per duration tick (0 acts as 1) |
| cont_i | input | 1 | Continuous replay mode |
| wrap_i | input | 1 | Wrap read pointer at window end |
| loop_en_i | input | 1 | Enable pass counting |
| loop_lim_i | input | 10 | Pass count limit |
| loop_rst_i | input | 1 | Clears the pass count |
| loop_stop_i | input | 1 | Halt when pass limit reached |
| thr_i | input | 9 | Entries-sent threshold |
| idle_lvl_i | input | 1 | Idle pin level |
| idle_en_i | input | 1 | Drive the pin while idle |
| mem_addr_o | output | 6 | RAM window read address / status |
| mem_data_i | input | 16 | RAM word at mem_addr_o (combinational read) |
| pin_o | output | 1 | Output level |
| pin_oe_o | output | 1 | Output enable |
| evt_end_o | output | 1 | End event pulse |
| evt_thr_o | output | 1 | Threshold event pulse |
| evt_loop_o | output | 1 | Loop event pulse |
| err_empty_o | output | 1 | Sticky window-overrun flag |
| state_o | output | 3 | Controller state |

## Verification
State and address move at the edge that samples a start or a fetched entry. The threshold and loop events are registered and show up in the cycle after the fetch that caused them. The pin takes the new level in the first SEND cycle, and a stop takes two edges: one to latch it and one to act on it. The bench advances a behavioural model by exactly one edge per clock, settles one time unit after the rising edge, and compares every output there. It also makes directed checks on counted busy cycles and event totals that are derived from these latencies.

// File: rtl/pts_pkg.sv
`timescale 1ns/1ps
package pts_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_SEND  = 3'd2,
        ST_DONE  = 3'd3
    } pts_state_e;
endpackage

// File: rtl/pts_tick_div.sv
`timescale 1ns/1ps
// Divides the clock into duration ticks while the sequencer is sending.
module pts_tick_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last;

    assign last = (div == '0) ? '0 : div - DIV_W'(1);
    assign tick = run && !clr && (cnt_q >= last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || clr || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + DIV_W'(1);
    end
endmodule

// File: rtl/pts_loop_ctr.sv
`timescale 1ns/1ps
// Counts completed passes; flags when the next increment lands on the limit.
module pts_loop_ctr #(
    parameter int LOOP_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    input  logic [LOOP_W-1:0] lim,
    output logic              reach_o
);
    logic [LOOP_W-1:0] cnt_q;
    logic [LOOP_W-1:0] cnt_nx;

    assign cnt_nx  = cnt_q + LOOP_W'(1);
    assign reach_o = (cnt_nx == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (inc)
            cnt_q <= cnt_nx;
    end
endmodule

// File: rtl/pts_rd_ptr.sv
`timescale 1ns/1ps
// Read pointer over the RAM window with optional wraparound.
module pts_rd_ptr #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    input  logic          wrap,
    output logic [AW-1:0] addr_o,
    output logic          last_o
);
    logic [AW-1:0] ptr_q;

    assign addr_o = ptr_q;
    assign last_o = (ptr_q == AW'(DEPTH - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (clr)
            ptr_q <= '0;
        else if (adv) begin
            if (last_o)
                ptr_q <= wrap ? '0 : ptr_q;
            else
                ptr_q <= ptr_q + AW'(1);
        end
    end
endmodule

// File: rtl/pulse_train_tx.sv
`timescale 1ns/1ps
module pulse_train_tx
    import pts_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int ENT_W  = 16,
    parameter int DIV_W  = 8,
    parameter int LOOP_W = 10,
    parameter int THR_W  = 9,
    localparam int AW     = $clog2(DEPTH),
    localparam int DUR_W  = ENT_W - 1,
    localparam int SENT_W = THR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              div_rst_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              cont_i,
    input  logic              wrap_i,
    input  logic              loop_en_i,
    input  logic [LOOP_W-1:0] loop_lim_i,
    input  logic              loop_rst_i,
    input  logic              loop_stop_i,
    input  logic [THR_W-1:0]  thr_i,
    input  logic              idle_lvl_i,
    input  logic              idle_en_i,
    output logic [AW-1:0]     mem_addr_o,
    input  logic [ENT_W-1:0]  mem_data_i,
    output logic              pin_o,
    output logic              pin_oe_o,
    output logic              evt_end_o,
    output logic              evt_thr_o,
    output logic              evt_loop_o,
    output logic              err_empty_o,
    output logic [2:0]        state_o
);
    pts_state_e state_q, state_d;

    logic [DUR_W-1:0]  remain_q;
    logic [SENT_W-1:0] sent_q;
    logic              lvl_q, ovf_q, err_q, stop_pend_q;
    logic              evt_thr_q, evt_loop_q;

    logic busy, halt, start_go, in_fetch, is_end, take;
    logic pass_end, loop_inc, loop_hit, auto_halt, restart;
    logic tick, send_last, ptr_last, reach;

    assign busy      = (state_q == ST_FETCH) || (state_q == ST_SEND);
    assign halt      = busy && stop_pend_q;
    assign start_go  = (state_q == ST_IDLE) && start_i;
    assign in_fetch  = (state_q == ST_FETCH) && !halt;
    assign is_end    = (mem_data_i[DUR_W-1:0] == '0);
    assign take      = in_fetch && !is_end;
    assign pass_end  = in_fetch && is_end;
    assign loop_inc  = pass_end && cont_i && loop_en_i;
    assign loop_hit  = loop_inc && reach;
    assign auto_halt = loop_hit && loop_stop_i;
    assign restart   = pass_end && cont_i && !auto_halt;
    assign send_last = (state_q == ST_SEND) && !halt && tick
                       && (remain_q == DUR_W'(1));

    pts_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  ((state_q == ST_SEND) && !stop_pend_q),
        .clr  (div_rst_i),
        .div  (div_i),
        .tick (tick)
    );

    pts_loop_ctr #(.LOOP_W(LOOP_W)) u_loop (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start_go || loop_rst_i),
        .inc    (loop_inc),
        .lim    (loop_lim_i),
        .reach_o(reach)
    );

    pts_rd_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_go || restart),
        .adv   (take),
        .wrap  (wrap_i),
        .addr_o(mem_addr_o),
        .last_o(ptr_last)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_FETCH;
            ST_FETCH: begin
                if (halt)                  state_d = ST_IDLE;
                else if (!is_end)          state_d = ST_SEND;
                else if (restart)          state_d = ST_FETCH;
                else                       state_d = ST_DONE;
            end
            ST_SEND: begin
                if (halt)                  state_d = ST_IDLE;
                else if (send_last)        state_d = ovf_q ? ST_DONE : ST_FETCH;
            end
            ST_DONE:                       state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q    <= '0;
            sent_q      <= '0;
            lvl_q       <= 1'b0;
            ovf_q       <= 1'b0;
            err_q       <= 1'b0;
            stop_pend_q <= 1'b0;
            evt_thr_q   <= 1'b0;
            evt_loop_q  <= 1'b0;
        end else begin
            evt_thr_q  <= take && (sent_q == {1'b0, thr_i});
            evt_loop_q <= loop_hit;

            if (!busy || stop_pend_q) stop_pend_q <= 1'b0;
            else if (stop_i)          stop_pend_q <= 1'b1;

            if (take)
                remain_q <= mem_data_i[DUR_W-1:0];
            else if ((state_q == ST_SEND) && !halt && tick && !send_last)
                remain_q <= remain_q - DUR_W'(1);

            if (start_go)  lvl_q <= idle_lvl_i;
            else if (take) lvl_q <= mem_data_i[ENT_W-1];

            if (start_go)                sent_q <= '0;
            else if (take && !(&sent_q)) sent_q <= sent_q + SENT_W'(1);

            if (start_go || restart)                ovf_q <= 1'b0;
            else if (take && ptr_last && !wrap_i)   ovf_q <= 1'b1;

            if (start_go)                err_q <= 1'b0;
            else if (send_last && ovf_q) err_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        pin_o       = busy ? lvl_q : (idle_en_i & idle_lvl_i);
        pin_oe_o    = busy | idle_en_i;
        evt_end_o   = (state_q == ST_DONE) && !err_q;
        evt_thr_o   = evt_thr_q;
        evt_loop_o  = evt_loop_q;
        err_empty_o = err_q;
        state_o     = state_q;
    end
endmodule

// File: rtl/pts_chk.sv
`timescale 1ns/1ps
module pts_chk #(
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter int ENT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             wrap_i,
    input logic             pend_i,
    input logic [2:0]       state_o,
    input logic [AW-1:0]    mem_addr_o,
    input logic [ENT_W-1:0] mem_data_i,
    input logic             evt_end_o,
    input logic             evt_thr_o,
    input logic             evt_loop_o,
    input logic             err_empty_o
);
    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && start_i) |=> (state_o == 3'd1 && mem_addr_o == '0));

    // R4
    end_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_end_o |=> (state_o == 3'd0));

    // R8
    evt_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_thr_o, evt_loop_o}));

    // R11
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && !pend_i && wrap_i && mem_addr_o == AW'(DEPTH - 1)
         && mem_data_i[ENT_W-2:0] != '0) |=> (mem_addr_o == '0));

    // R12
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_empty_o && !start_i) |=> err_empty_o);
endmodule

bind pulse_train_tx pts_chk #(.DEPTH(DEPTH), .AW(AW), .ENT_W(ENT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .wrap_i     (wrap_i),
    .pend_i     (stop_pend_q),
    .state_o    (state_o),
    .mem_addr_o (mem_addr_o),
    .mem_data_i (mem_data_i),
    .evt_end_o  (evt_end_o),
    .evt_thr_o  (evt_thr_o),
    .evt_loop_o (evt_loop_o),
    .err_empty_o(err_empty_o)
);

// File: tb/pulse_train_tx_bench.sv
`timescale 1ns/1ps
module pulse_train_tx_bench;
    localparam int DEPTH = 64;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic start_i = 0, stop_i = 0, div_rst_i = 0;
    logic [7:0] div_i = 8'd2;
    logic cont_i = 0, wrap_i = 0, loop_en_i = 0, loop_rst_i = 0, loop_stop_i = 0;
    logic [9:0] loop_lim_i = 10'd0;
    logic [8:0] thr_i = 9'd128;
    logic idle_lvl_i = 1, idle_en_i = 1;
    logic [5:0]  mem_addr_o;
    logic [15:0] mem_data_i;
    logic pin_o, pin_oe_o, evt_end_o, evt_thr_o, evt_loop_o, err_empty_o;
    logic [2:0] state_o;

    logic [15:0] mem [DEPTH];
    assign mem_data_i = mem[mem_addr_o];

    pulse_train_tx u_pulse_train_tx (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .div_rst_i(div_rst_i), .div_i(div_i), .cont_i(cont_i), .wrap_i(wrap_i),
        .loop_en_i(loop_en_i), .loop_lim_i(loop_lim_i), .loop_rst_i(loop_rst_i),
        .loop_stop_i(loop_stop_i), .thr_i(thr_i), .idle_lvl_i(idle_lvl_i),
        .idle_en_i(idle_en_i), .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
        .pin_o(pin_o), .pin_oe_o(pin_oe_o), .evt_end_o(evt_end_o),
        .evt_thr_o(evt_thr_o), .evt_loop_o(evt_loop_o),
        .err_empty_o(err_empty_o), .state_o(state_o)
    );

    int checks = 0, fails = 0, cycles = 0;
    bit finished = 0;
    string cur_req = "R1";
    int n_end = 0, n_thr = 0, n_loop = 0, n_busy = 0, saw_wrap = 0, prev_addr = 0;

    // behavioural model state
    int m_st = 0, m_ptr = 0, m_rem = 0, m_dc = 0, m_lvl = 0, m_sent = 0;
    int m_loop = 0, m_err = 0, m_ovf = 0, m_pend = 0, m_ethr = 0, m_eloop = 0;
    int n_st, n_ptr, n_rem, n_dc, n_lvl, n_sent, n_loopc, n_err, n_ovf, n_pend, n_ethr, n_eloop;

    task automatic expect_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s [%s] %s: actual=%0d expected=%0d", req, cur_req, what, act, exp);
        end
    endtask

    task automatic model_step();
        int d, lim, busy, hit;
        busy = (m_st == 1 || m_st == 2);
        n_st = m_st; n_ptr = m_ptr; n_rem = m_rem; n_dc = 0; n_lvl = m_lvl;
        n_sent = m_sent; n_loopc = m_loop; n_err = m_err; n_ovf = m_ovf;
        n_ethr = 0; n_eloop = 0;
        n_pend = (!busy || m_pend) ? 0 : (stop_i ? 1 : 0);
        if (busy && m_pend) n_st = 0;
        else case (m_st)
            0: if (start_i) begin
                n_st = 1; n_ptr = 0; n_sent = 0; n_err = 0; n_ovf = 0;
                n_lvl = idle_lvl_i; n_loopc = 0;
            end
            1: begin
                d = mem[m_ptr] & 16'h7fff;
                if (d == 0) begin
                    if (cont_i) begin
                        hit = loop_en_i && (((m_loop + 1) % 1024) == loop_lim_i);
                        if (loop_en_i) n_loopc = (m_loop + 1) % 1024;
                        n_eloop = hit;
                        if (hit && loop_stop_i) n_st = 3;
                        else begin n_st = 1; n_ptr = 0; n_ovf = 0; end
                    end else n_st = 3;
                end else begin
                    n_lvl = mem[m_ptr][15]; n_rem = d;
                    if (m_sent == thr_i) n_ethr = 1;
                    if (m_sent < 1023) n_sent = m_sent + 1;
                    if (m_ptr == DEPTH - 1) begin
                        if (wrap_i) n_ptr = 0; else n_ovf = 1;
                    end else n_ptr = m_ptr + 1;
                    n_st = 2;
                end
            end
            2: if (!div_rst_i) begin
                lim = (div_i == 0) ? 0 : div_i - 1;
                if (m_dc >= lim) begin
                    if (m_rem == 1) begin
                        if (m_ovf) begin n_st = 3; n_err = 1; end
                        else n_st = 1;
                    end else n_rem = m_rem - 1;
                end else n_dc = m_dc + 1;
            end
            default: n_st = 0;
        endcase
        if (loop_rst_i) n_loopc = 0;
    endtask

    task automatic finish_report();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    task automatic tick();
        int busy, epin;
        model_step();
        @(posedge clk);
        #1;
        cycles++;
        if (cycles > 150000) begin
            fails++; checks++;
            $display("FAIL watchdog [%s]: actual=%0d expected<=%0d", cur_req, cycles, 150000);
            finish_report();
        end
        if (!rst_n) begin
            m_st = 0; m_ptr = 0; m_rem = 0; m_dc = 0; m_lvl = 0; m_sent = 0;
            m_loop = 0; m_err = 0; m_ovf = 0; m_pend = 0; m_ethr = 0; m_eloop = 0;
        end else begin
            m_st = n_st; m_ptr = n_ptr; m_rem = n_rem; m_dc = n_dc; m_lvl = n_lvl;
            m_sent = n_sent; m_loop = n_loopc; m_err = n_err; m_ovf = n_ovf;
            m_pend = n_pend; m_ethr = n_ethr; m_eloop = n_eloop;
            busy = (m_st == 1 || m_st == 2);
            epin = busy ? m_lvl : (idle_en_i & idle_lvl_i);
            expect_eq("R14", "state", state_o, m_st);
            expect_eq("R14", "addr", mem_addr_o, m_ptr);
            expect_eq("R3", "pin", pin_o, epin);
            expect_eq("R13", "pin_oe", pin_oe_o, busy | idle_en_i);
            expect_eq("R4", "evt_end", evt_end_o, (m_st == 3 && !m_err));
            expect_eq("R10", "evt_thr", evt_thr_o, m_ethr);
            expect_eq("R8", "evt_loop", evt_loop_o, m_eloop);
            expect_eq("R12", "err", err_empty_o, m_err);
            n_end += evt_end_o; n_thr += evt_thr_o; n_loop += evt_loop_o;
            if (state_o == 3'd1 || state_o == 3'd2) n_busy++;
            if (busy && mem_addr_o == 0 && prev_addr == DEPTH - 1) saw_wrap++;
            prev_addr = mem_addr_o;
        end
    endtask

    task automatic pulse_start();  start_i = 1;  tick(); start_i = 0;  endtask
    task automatic pulse_stop();   stop_i = 1;   tick(); stop_i = 0;   endtask
    task automatic pulse_divrst(); div_rst_i = 1; tick(); div_rst_i = 0; endtask
    task automatic pulse_looprst(); loop_rst_i = 1; tick(); loop_rst_i = 0; endtask
    task automatic ticks(int n); repeat (n) tick(); endtask
    task automatic run_idle(int max);
        for (int k = 0; k < max && state_o != 3'd0; k++) tick();
    endtask
    task automatic clr_counts();
        n_end = 0; n_thr = 0; n_loop = 0; n_busy = 0; saw_wrap = 0;
    endtask
    task automatic load_basic();
        for (int i = 0; i < DEPTH; i++) mem[i] = 16'h0000;
        mem[0] = {1'b1, 15'd3}; mem[1] = {1'b0, 15'd2}; mem[2] = {1'b1, 15'd1};
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog [%s]: actual=timeout expected=finish", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        load_basic();
        // R1: reset state
        ticks(3);
        rst_n = 1;
        tick();
        expect_eq("R1", "reset state", state_o, 0);
        expect_eq("R1", "reset addr", mem_addr_o, 0);
        expect_eq("R1", "reset events", {evt_end_o, evt_thr_o, evt_loop_o, err_empty_o}, 0);
        expect_eq("R13", "idle pin", pin_o, 1);

        // R2, R3, R4: basic run, start while busy ignored
        cur_req = "R2"; clr_counts();
        pulse_start();
        expect_eq("R2", "state after start", state_o, 1);
        expect_eq("R2", "addr after start", mem_addr_o, 0);
        ticks(3); pulse_start();
        run_idle(200);
        expect_eq("R4", "end events", n_end, 1);
        expect_eq("R3", "busy cycles div2", n_busy, 7 + 5 + 3 + 1);

        // R3: divider 3 and 0
        cur_req = "R3"; div_i = 8'd3; clr_counts();
        pulse_start(); run_idle(200);
        expect_eq("R3", "busy cycles div3", n_busy, 22);
        div_i = 8'd0; clr_counts();
        pulse_start(); run_idle(200);
        expect_eq("R3", "busy cycles div0", n_busy, 10);

        // R5: stop while busy, then stop while idle
        cur_req = "R5"; div_i = 8'd2; clr_counts();
        pulse_start(); ticks(4); pulse_stop(); tick();
        expect_eq("R5", "state after stop", state_o, 0);
        expect_eq("R5", "no end on stop", n_end, 0);
        pulse_stop(); pulse_start(); run_idle(200);
        expect_eq("R5", "idle stop ignored", n_end, 1);

        // R6: divider reset lengthens current tick
        cur_req = "R6"; div_i = 8'd4; clr_counts();
        pulse_start(); ticks(2); pulse_divrst(); run_idle(300);
        expect_eq("R6", "busy cycles with div reset", n_busy, 30);

        // R7, R9, R10: continuous with auto-stop at limit 3, threshold 4
        cur_req = "R9"; div_i = 8'd1; clr_counts();
        for (int i = 0; i < DEPTH; i++) mem[i] = 16'h0000;
        mem[0] = {1'b1, 15'd2}; mem[1] = {1'b0, 15'd1};
        cont_i = 1; loop_en_i = 1; loop_lim_i = 10'd3; loop_stop_i = 1; thr_i = 9'd4;
        pulse_start(); run_idle(300);
        expect_eq("R7", "busy cycles three passes", n_busy, 18);
        expect_eq("R9", "end on limit", n_end, 1);
        expect_eq("R8", "loop events", n_loop, 1);
        expect_eq("R10", "threshold events", n_thr, 1);

        // R8: free-running with loop reset
        cur_req = "R8"; loop_stop_i = 0; loop_lim_i = 10'd2; thr_i = 9'd200; clr_counts();
        pulse_start(); ticks(12);
        expect_eq("R7", "still running", state_o != 0, 1);
        pulse_looprst(); ticks(14);
        pulse_stop(); run_idle(10);
        expect_eq("R8", "loop events with reset", n_loop, 2);
        expect_eq("R7", "no end in continuous", n_end, 0);

        // R11: wraparound over full window
        cur_req = "R11"; cont_i = 0; loop_en_i = 0; wrap_i = 1; clr_counts();
        for (int i = 0; i < DEPTH; i++) mem[i] = {i[0], 15'd1};
        pulse_start(); ticks(140); pulse_stop(); run_idle(10);
        expect_eq("R11", "wrapped to 0", saw_wrap, 1);

        // R12, R13: overrun without wrap
        cur_req = "R12"; wrap_i = 0; clr_counts();
        pulse_start(); run_idle(300);
        expect_eq("R12", "error set", err_empty_o, 1);
        expect_eq("R12", "no end on overrun", n_end, 0);
        ticks(3);
        expect_eq("R12", "error sticky", err_empty_o, 1);
        idle_en_i = 0; tick();
        expect_eq("R13", "oe off when idle", pin_oe_o, 0);
        expect_eq("R13", "pin low when idle", pin_o, 0);
        pulse_start();
        expect_eq("R12", "error cleared by start", err_empty_o, 0);
        pulse_stop(); run_idle(10);

        finish_report();
    end
endmodule